// File: doc/BRIEF.md
# Synchronous Shift-Mode Serial Port

This block is a byte-wide serial port that works only in synchronous shift mode. Software reaches it through a small register bus with four locations: control, transmit buffer, receive buffer and status. Each frame is 8 bits, least significant bit first, over one shared data line. The port always drives the shift clock, whether it is sending or receiving. A transmit starts when software writes the transmit buffer. When clear-to-send gating is on, a pending transmit also waits until the asynchronous `cts_in` level has passed through a synchronizer and is seen high. A receive starts when software sets the receive enable while the receive-complete flag is clear. After 8 bits the port loads the receive buffer, raises the flag and drops the enable.

The register bus has no back-pressure. Every access completes in the cycle it is presented, and read data is combinational on `bus_addr`. Software polls the transmit-free status bit before writing the transmit buffer. A write to a full buffer replaces the pending byte. The data pin is modelled as three plain ports: `sdata_out`, `sdata_oe` and `sdata_in`. The shift clock half-period is the parameter `HALF_DIV`, counted in system clocks.

Register map:
- `bus_addr` 0 is control: [2:0] mode, [3] cts enable, [4] receive enable, [5] break, [7:6] spare.
- `bus_addr` 1 is the transmit buffer (write).
- `bus_addr` 2 is the receive buffer (read).
- `bus_addr` 3 is status: [0] tx free, [1] tx empty, [2] rx done, [7:3] zero.

Top module: `ssp_port`

## Requirements
- R1: After reset, status reads 8'h03, `sclk_out` is high, `sdata_oe` is low and the receive buffer reads 8'h00.
- R2: Status bit 0 (tx free) is 1 when the transmit buffer holds no pending byte. Status bit 1 (tx empty) is 1 only when the buffer is free and no transmit is shifting. Two back-to-back writes give status 8'h00 while the first byte shifts.
- R3: A transmit drives 8 bits, LSB first, with `sdata_oe` high. Each bit is stable across a rising edge of `sclk_out`, which idles high and toggles every `HALF_DIV` clocks while shifting. Buffered bytes go out in write order.
- R4: With control bit 3 set, a pending transmit waits until `cts_in` has been high through a two-flop synchronizer. A `cts_in` pulse that ends before the buffer write has no effect.
- R5: With control bit 3 clear, a written byte starts shifting on the next clock edge, whatever the level of `cts_in`.
- R6: Writing control bit 4 = 1 while rx done is clear starts a receive. It runs 8 `sclk_out` periods with `sdata_oe` low and samples `sdata_in` on each rising edge, LSB first.
- R7: When a receive completes, the byte is loaded into the receive buffer, status bit 2 is set and control bit 4 reads 0. A read of the receive buffer clears status bit 2.
- R8: Writing control bit 4 = 1 while status bit 2 is set is ignored. The bit reads 0 and no shift clock runs.
- R9: Only mode value 3'b000 allows a transfer to start. With any other mode, pending transmits and receives wait and resume once the mode returns to 3'b000.
- R10: Status bits [7:3] (error and break flags) always read 0. Control bit 5 drives `brk_out` and does not change shifting.
- R11: A receive enabled while a transmit is active, or pending and allowed to start, is deferred and starts after the transmit finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears rx done on a receive buffer read) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on bus_addr |
| sdata_in | input | 1 | Serial data line, input side |
| sdata_out | output | 1 | Serial data line, output side |
| sdata_oe | output | 1 | Serial data line drive enable (high during transmit) |
| sclk_out | output | 1 | Shift clock, idles high |
| cts_in | input | 1 | Asynchronous clear-to-send level, active high |
| brk_out | output | 1 | Break control level from control bit 5 |

## Verification
The bench pulses `cts_in` before a gated buffer write and then checks that nothing shifts. A design that latched the pulse instead of sensing the level would send the byte early. It also sets the receive enable while the rx done flag is still set. A design that ignored the flag would run a second clock burst and overwrite the unread byte. A receive is requested during a transmit, so a design without deferral would let `sdata_oe` and the receive clocks collide and corrupt both bytes. A non-shift mode value must hold a pending byte. Two back-to-back buffer writes must leave `tx free` low and go out in order, or a loss or reordering shows up in the scoreboard.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam logic [1:0] ADR_CTRL  = 2'd0;
  localparam logic [1:0] ADR_TXBUF = 2'd1;
  localparam logic [1:0] ADR_RXBUF = 2'd2;
  localparam logic [1:0] ADR_STAT  = 2'd3;

  localparam logic [2:0] MODE_SHIFT = 3'd0;

  localparam int CB_CTS  = 3;
  localparam int CB_RXEN = 4;
  localparam int CB_BRK  = 5;

  localparam int SB_TXFREE  = 0;
  localparam int SB_TXEMPTY = 1;
  localparam int SB_RXDONE  = 2;
endpackage

// File: rtl/ssp_baud.sv
module ssp_baud #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || tick) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ssp_cts_sync.sv
module ssp_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= async_in;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         start_tx,
  input  logic         start_rx,
  input  logic [W-1:0] tx_data,
  input  logic         sdata_in,
  output logic         busy,
  output logic         dir_tx,
  output logic         sclk,
  output logic         done,
  output logic         out_bit,
  output logic [W-1:0] rx_data
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  shreg_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      dir_tx  <= 1'b0;
      sclk    <= 1'b1;
      done    <= 1'b0;
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (!busy) begin
      done <= 1'b0;
      sclk <= 1'b1;
      if (start_tx || start_rx) begin
        busy    <= 1'b1;
        dir_tx  <= start_tx;
        shreg_q <= start_tx ? tx_data : '0;
        cnt_q   <= '0;
      end
    end else if (tick) begin
      if (sclk) begin
        // falling edge: present the next transmit bit (bit 0 already out)
        sclk <= 1'b0;
        if (dir_tx && cnt_q != '0) shreg_q <= shreg_q >> 1;
      end else begin
        // rising edge: receiver samples, frame may end
        sclk <= 1'b1;
        if (!dir_tx) shreg_q <= {sdata_in, shreg_q[W-1:1]};
        if (cnt_q == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign out_bit = shreg_q[0];
  assign rx_data = shreg_q;
endmodule

// File: rtl/ssp_port.sv
module ssp_port
  import ssp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sdata_in,
  output logic              sdata_out,
  output logic              sdata_oe,
  output logic              sclk_out,
  input  logic              cts_in,
  output logic              brk_out
);
  logic [2:0]        mode_q;
  logic              cts_en_q, rx_en_q, brk_q;
  logic [DATA_W-1:6] spare_q;
  logic [DATA_W-1:0] tx_buf_q, rx_buf_q;
  logic              tx_full_q, rx_done_q;

  logic              cts_s, tick;
  logic              sh_busy, sh_dir_tx, sh_sclk, sh_done, sh_bit;
  logic [DATA_W-1:0] sh_rx_data;
  logic              mode_ok, idle, start_tx, start_rx;

  ssp_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(cts_in), .sync_out(cts_s)
  );

  ssp_baud #(.HALF_DIV(HALF_DIV)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(sh_busy), .tick(tick)
  );

  ssp_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .start_tx(start_tx), .start_rx(start_rx), .tx_data(tx_buf_q),
    .sdata_in(sdata_in), .busy(sh_busy), .dir_tx(sh_dir_tx),
    .sclk(sh_sclk), .done(sh_done), .out_bit(sh_bit), .rx_data(sh_rx_data)
  );

  assign mode_ok  = (mode_q == MODE_SHIFT);
  assign idle     = !sh_busy && !sh_done;
  assign start_tx = idle && mode_ok && tx_full_q && (!cts_en_q || cts_s);
  assign start_rx = idle && mode_ok && rx_en_q && !start_tx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= MODE_SHIFT;
      cts_en_q  <= 1'b0;
      rx_en_q   <= 1'b0;
      brk_q     <= 1'b0;
      spare_q   <= '0;
      tx_buf_q  <= '0;
      tx_full_q <= 1'b0;
      rx_buf_q  <= '0;
      rx_done_q <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == ADR_CTRL) begin
        mode_q   <= bus_wdata[2:0];
        cts_en_q <= bus_wdata[CB_CTS];
        brk_q    <= bus_wdata[CB_BRK];
        spare_q  <= bus_wdata[DATA_W-1:6];
        rx_en_q  <= bus_wdata[CB_RXEN] && !rx_done_q;
      end
      if (sh_done && !sh_dir_tx) rx_en_q <= 1'b0;

      if (bus_wr && bus_addr == ADR_TXBUF) begin
        tx_buf_q  <= bus_wdata;
        tx_full_q <= 1'b1;
      end else if (start_tx) begin
        tx_full_q <= 1'b0;
      end

      if (sh_done && !sh_dir_tx) begin
        rx_buf_q  <= sh_rx_data;
        rx_done_q <= 1'b1;
      end else if (bus_rd && bus_addr == ADR_RXBUF) begin
        rx_done_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_CTRL: begin
        bus_rdata[2:0]        = mode_q;
        bus_rdata[CB_CTS]     = cts_en_q;
        bus_rdata[CB_RXEN]    = rx_en_q;
        bus_rdata[CB_BRK]     = brk_q;
        bus_rdata[DATA_W-1:6] = spare_q;
      end
      ADR_RXBUF: bus_rdata = rx_buf_q;
      ADR_STAT: begin
        bus_rdata[SB_TXFREE]  = !tx_full_q;
        bus_rdata[SB_TXEMPTY] = !tx_full_q && !(sh_busy && sh_dir_tx);
        bus_rdata[SB_RXDONE]  = rx_done_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign sdata_oe  = sh_busy && sh_dir_tx;
  assign sdata_out = sdata_oe ? sh_bit : 1'b1;
  assign sclk_out  = sh_sclk;
  assign brk_out   = brk_q;
endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       dir_tx,
  input logic       sclk,
  input logic       cts_en,
  input logic       cts_s,
  input logic [2:0] mode,
  input logic       rx_en,
  input logic       rx_done
);
  // R3
  idle_clock_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk);

  // R4
  cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && dir_tx && $past(cts_en)) |-> $past(cts_s));

  // R9
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(mode) == 3'd0));

  // R6
  rx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !dir_tx) |-> ($past(rx_en) && !$past(rx_done)));

  // R7
  rx_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> !rx_en);

  // R8
  rx_enable_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_en) |-> !$past(rx_done));
endmodule

bind ssp_port ssp_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(sh_busy), .dir_tx(sh_dir_tx),
  .sclk(sh_sclk), .cts_en(cts_en_q), .cts_s(cts_s), .mode(mode_q),
  .rx_en(rx_en_q), .rx_done(rx_done_q)
);

// File: tb/ssp_port_bench.sv
module ssp_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       sdata_in = 1'b1;
  logic       sdata_out, sdata_oe, sclk_out, brk_out;
  logic       cts_in = 1'b0;

  always #10 clk = ~clk;

  ssp_port u_ssp_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sdata_in(sdata_in), .sdata_out(sdata_out), .sdata_oe(sdata_oe),
    .sclk_out(sclk_out), .cts_in(cts_in), .brk_out(brk_out)
  );

  int checks = 0, fails = 0;
  int rises = 0;
  logic [7:0] expq[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  // driver: expected byte goes to the scoreboard, then to the buffer
  task automatic tx_push(input logic [7:0] b);
    expq.push_back(b);
    wr(2'd1, b);
  endtask

  task automatic drain(input string req);
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd3, s);
      if (s == 8'h03 && expq.size() == 0) break;
    end
    repeat (2) @(negedge clk);
    check(expq.size() == 0, req, expq.size(), 0);
  endtask

  task automatic wait_rx_done();
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd3, s);
      if (s[2]) break;
    end
  endtask

  task automatic rx_drive(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      @(negedge sclk_out);
      sdata_in = b[i];
    end
  endtask

  // monitor: rebuild transmitted frames and compare against the scoreboard
  logic       prev_sclk = 1'b1, prev_oe = 1'b0, last_bit = 1'b1;
  logic [7:0] frame = '0;
  int         nbit = 0;
  always @(negedge clk) begin
    if (rst_n && !prev_sclk && sclk_out) begin
      rises++;
      if (prev_oe) begin
        frame[nbit] = last_bit;
        nbit++;
        if (nbit == 8) begin
          nbit = 0;
          if (expq.size() == 0) check(1'b0, "R3 unexpected frame", frame, 0);
          else begin
            logic [7:0] e;
            e = expq.pop_front();
            check(frame == e, "R3 frame", frame, e);
          end
        end
      end
    end
    prev_sclk = sclk_out;
    prev_oe   = sdata_oe;
    last_bit  = sdata_out;
  end

  initial begin
    #(20 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int r0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd3, d);  check(d == 8'h03, "R1 status", d, 8'h03);
    check(sclk_out == 1'b1 && sdata_oe == 1'b0, "R1 pins", {sclk_out, sdata_oe}, 2'b10);
    rd(2'd2, d);  check(d == 8'h00, "R1 rxbuf", d, 0);

    // R5 ungated start, R2 status, R3 order
    wr(2'd0, 8'h00);
    cts_in = 1'b0;
    tx_push(8'hA5);
    rd(2'd3, d);  check(d == 8'h01, "R2 shifting", d, 8'h01);
    check(sdata_oe == 1'b1, "R5 started without cts", sdata_oe, 1);
    tx_push(8'h3C);
    rd(2'd3, d);  check(d == 8'h00, "R2 buffer full", d, 8'h00);
    drain("R3 two frames");
    rd(2'd3, d);  check(d == 8'h03, "R2 idle", d, 8'h03);

    // R4 cts gating; early pulse ignored
    wr(2'd0, 8'h08);
    cts_in = 1'b1; repeat (3) @(negedge clk); cts_in = 1'b0;
    repeat (4) @(negedge clk);
    r0 = rises;
    tx_push(8'hC3);
    repeat (60) @(negedge clk);
    check(sdata_oe == 1'b0 && rises == r0, "R4 held without cts", rises - r0, 0);
    rd(2'd3, d);  check(d == 8'h00, "R4 pending", d, 8'h00);
    cts_in = 1'b1;
    drain("R4 sent after cts");
    cts_in = 1'b0;

    // R6 / R7 receive
    wr(2'd0, 8'h10);
    rx_drive(8'h96);
    wait_rx_done();
    rd(2'd0, d);  check(d[4] == 1'b0, "R7 rx enable cleared", d, 8'h00);
    rd(2'd2, d);  check(d == 8'h96, "R6 rx byte", d, 8'h96);
    rd(2'd3, d);  check(d == 8'h03, "R7 flag cleared by read", d, 8'h03);

    // R8 enable ignored while flag set
    wr(2'd0, 8'h10);
    rx_drive(8'h5E);
    wait_rx_done();
    r0 = rises;
    wr(2'd0, 8'h10);
    repeat (50) @(negedge clk);
    rd(2'd0, d);  check(d[4] == 1'b0, "R8 enable stays clear", d, 8'h00);
    check(rises == r0, "R8 no clock burst", rises - r0, 0);
    rd(2'd2, d);  check(d == 8'h5E, "R8 buffer kept", d, 8'h5E);

    // R11 receive deferred behind transmit
    wr(2'd0, 8'h00);
    tx_push(8'h81);
    wr(2'd0, 8'h10);
    if (sdata_oe) @(negedge sdata_oe);
    rx_drive(8'hE7);
    wait_rx_done();
    rd(2'd2, d);  check(d == 8'hE7, "R11 deferred rx byte", d, 8'hE7);
    check(expq.size() == 0, "R11 tx completed", expq.size(), 0);

    // R9 non-shift mode holds transfers
    wr(2'd0, 8'h01);
    r0 = rises;
    tx_push(8'h42);
    repeat (60) @(negedge clk);
    check(sdata_oe == 1'b0 && rises == r0, "R9 held in other mode", rises - r0, 0);
    wr(2'd0, 8'h00);
    drain("R9 resumed");

    // R10 break bit and zero error flags
    wr(2'd0, 8'h20);
    @(negedge clk);
    check(brk_out == 1'b1, "R10 break out", brk_out, 1);
    tx_push(8'h7E);
    rd(2'd3, d);  check(d[7:3] == 5'd0, "R10 flags zero", d, 8'h01);
    drain("R10 shift with break");
    wr(2'd0, 8'h00);
    @(negedge clk);
    check(brk_out == 1'b0, "R10 break clear", brk_out, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule